// File: doc/BRIEF.md
# Timestamp interrupt coalescing controller

This block decides when a timestamping front end should interrupt its host. It watches one write strobe per timestamp FIFO and raises a single interrupt pulse on one of two conditions. The first is that any one FIFO has collected more new timestamps than a programmed count limit since the last interrupt. The second is that a programmed number of milliseconds has elapsed since the last interrupt while at least one timestamp has arrived in that interval. Grouping the timestamps this way keeps the host from being interrupted once per timestamp, and the time condition still delivers the data when traffic is sparse.

A free-running prescaler divides the clock into millisecond ticks. Every interrupt restarts the prescaler, the millisecond count, the per-FIFO counts and the "timestamp seen" flag. One active-high acquisition enable gates all strobes. The two limits are plain inputs that the surrounding register logic holds steady.

Top module: `tsirq_coalesce`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `irq_o` is low, and all counts and timers start from zero.
- R2: Each FIFO has a count that rises by one on every accepted strobe. One clock edge after a count becomes strictly greater than `cnt_limit_i`, `irq_o` is high for that cycle.
- R3: The count condition is evaluated per FIFO. Strobes spread across FIFOs, none of which exceeds the limit on its own, raise no interrupt, even when their sum does.
- R4: A strobe is accepted only when `acq_en_i` is 1. A strobe seen while `acq_en_i` is 0 does not count and does not arm the time condition.
- R5: A millisecond is `MS_DIV` clock cycles. With `ms_limit_i` = N > 0 and at least one accepted strobe since the last restart, `irq_o` pulses on the clock edge `N*MS_DIV + 1` edges after that restart.
- R6: If no strobe has been accepted since the last restart, the time condition never raises `irq_o`.
- R7: With `ms_limit_i` = 0 the time condition is disabled, and only the count condition can interrupt.
- R8: The edge that raises `irq_o` also restarts the counts, the prescaler, the millisecond count and the seen flag. A strobe accepted on that same edge counts as the first strobe of the new interval.
- R9: An 8-bit FIFO count saturates at 255 and does not wrap, so it keeps that value until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_en_i | input | 1 | Acquisition enable for every FIFO, active high |
| ts_wr_i | input | NUM_CH | One timestamp-write strobe per FIFO |
| cnt_limit_i | input | 8 | Count limit; interrupt when a FIFO count exceeds it |
| ms_limit_i | input | 32 | Time limit in milliseconds; 0 disables it |
| irq_o | output | 1 | Interrupt pulse, one cycle per decision |

## Verification
The bound checker checks on every cycle that any count above the limit is followed by an interrupt, and so is a due timeout. It also checks that no timeout fires with the seen flag clear or with the limit at zero, that a disabled acquisition freezes every count, that the millisecond count is zero in the cycle the pulse is high, and that a saturated count holds. The bench scenarios cover what needs a whole stimulus history. These are the exact cycle on which a timeout fires, the evidence that the timer restarts at a count interrupt rather than at reset, the per-FIFO split of strobes, the counting of a strobe that coincides with the pulse, and saturation observed at the interrupt output by lowering the limit after a long burst.

// File: rtl/tsirq_pkg.sv
package tsirq_pkg;

    localparam int CNT_W = 8;
    localparam int MS_W  = 32;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [MS_W-1:0]  ms_t;

    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};
    localparam ms_t  MS_MAX  = {MS_W{1'b1}};

    typedef struct packed {
        cnt_t cnt;
    } chan_state_t;

    typedef struct packed {
        ms_t  ms;
        logic seen;
    } timer_state_t;

    typedef struct packed {
        logic irq;
    } top_state_t;

endpackage

// File: rtl/tsirq_tick_gen.sv
module tsirq_tick_gen #(
    parameter int MS_DIV = 125000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    output logic tick_o
);

    localparam int PW = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(MS_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    assign tick_o = (st_q.pre == LAST);

    always_comb begin
        st_d = st_q;
        if (clear_i || tick_o) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsirq_chan_counter.sv
module tsirq_chan_counter
    import tsirq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stamp_i,
    input  logic clear_i,
    input  cnt_t limit_i,
    output cnt_t cnt_o,
    output logic over_o
);

    chan_state_t st_d, st_q;

    assign cnt_o  = st_q.cnt;
    assign over_o = (st_q.cnt > limit_i);

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = stamp_i ? cnt_t'(1) : '0;
        end else if (stamp_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsirq_ms_timer.sv
module tsirq_ms_timer
    import tsirq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic stamp_i,
    input  logic clear_i,
    input  ms_t  limit_i,
    output ms_t  ms_o,
    output logic seen_o,
    output logic due_o
);

    timer_state_t st_d, st_q;

    assign ms_o   = st_q.ms;
    assign seen_o = st_q.seen;
    assign due_o  = (limit_i != '0) && st_q.seen && (st_q.ms >= limit_i);

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.ms   = '0;
            st_d.seen = stamp_i;
        end else begin
            st_d.seen = st_q.seen | stamp_i;
            if (tick_i && (st_q.ms != MS_MAX)) begin
                st_d.ms = st_q.ms + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsirq_coalesce.sv
module tsirq_coalesce
    import tsirq_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int MS_DIV = 125000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acq_en_i,
    input  logic [NUM_CH-1:0] ts_wr_i,
    input  logic [CNT_W-1:0]  cnt_limit_i,
    input  logic [MS_W-1:0]   ms_limit_i,
    output logic              irq_o
);

    localparam int FLAT_W = NUM_CH * CNT_W;

    logic [NUM_CH-1:0] accepted;
    logic [NUM_CH-1:0] over;
    logic [FLAT_W-1:0] cnt_flat;
    logic              any_stamp;
    logic              tick;
    logic              due;
    logic              fire;
    ms_t               ms_now;
    logic              seen_now;

    top_state_t st_d, st_q;

    assign accepted  = ts_wr_i & {NUM_CH{acq_en_i}};
    assign any_stamp = |accepted;
    assign fire      = (|over) | due;
    assign irq_o     = st_q.irq;

    tsirq_tick_gen #(
        .MS_DIV (MS_DIV)
    ) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (fire),
        .tick_o  (tick)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        cnt_t cnt_ch;
        tsirq_chan_counter u_cnt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .stamp_i (accepted[ch]),
            .clear_i (fire),
            .limit_i (cnt_limit_i),
            .cnt_o   (cnt_ch),
            .over_o  (over[ch])
        );
        assign cnt_flat[ch*CNT_W +: CNT_W] = cnt_ch;
    end

    tsirq_ms_timer u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .stamp_i (any_stamp),
        .clear_i (fire),
        .limit_i (ms_limit_i),
        .ms_o    (ms_now),
        .seen_o  (seen_now),
        .due_o   (due)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = fire;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsirq_coalesce_chk.sv
module tsirq_coalesce_chk #(
    parameter int NUM_CH = 5
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                acq_en_i,
    input logic [7:0]          cnt_limit_i,
    input logic [31:0]         ms_limit_i,
    input logic                irq_o,
    input logic [NUM_CH*8-1:0] cnt_flat,
    input logic [31:0]         ms_now,
    input logic                seen_now
);

    logic any_above;
    always_comb begin
        any_above = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cnt_flat[i*8 +: 8] > cnt_limit_i) any_above = 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        !rst_ni |=> !irq_o);

    assert_count_fires_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_above |=> irq_o);

    assert_time_fires_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_now && (ms_limit_i != 32'd0) && (ms_now >= ms_limit_i)) |=> irq_o);

    assert_no_stamp_no_timeout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!seen_now && !any_above) |=> !irq_o);

    assert_zero_limit_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ms_limit_i == 32'd0) && !any_above) |=> !irq_o);

    assert_restart_on_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (ms_now == 32'd0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_enable_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !acq_en_i |=> ((cnt_flat[c*8 +: 8] == $past(cnt_flat[c*8 +: 8]))
                           || (cnt_flat[c*8 +: 8] == 8'd0)));

        assert_saturate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cnt_flat[c*8 +: 8] == 8'hFF) |=> ((cnt_flat[c*8 +: 8] == 8'hFF)
                                              || (cnt_flat[c*8 +: 8] <= 8'd1)));
    end

endmodule

bind tsirq_coalesce tsirq_coalesce_chk #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acq_en_i    (acq_en_i),
    .cnt_limit_i (cnt_limit_i),
    .ms_limit_i  (ms_limit_i),
    .irq_o       (irq_o),
    .cnt_flat    (cnt_flat),
    .ms_now      (ms_now),
    .seen_now    (seen_now)
);

// File: tb/tsirq_coalesce_bench.sv
module tsirq_coalesce_bench;

    localparam int NUM_CH = 5;
    localparam int MS_DIV = 10;

    logic              clk;
    logic              rst_n;
    logic              acq_en;
    logic [NUM_CH-1:0] ts_wr;
    logic [7:0]        cnt_lim;
    logic [31:0]       ms_lim;
    logic              irq;

    int n_chk;
    int n_fail;

    tsirq_coalesce #(
        .NUM_CH (NUM_CH),
        .MS_DIV (MS_DIV)
    ) u_tsirq_coalesce (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .acq_en_i    (acq_en),
        .ts_wr_i     (ts_wr),
        .cnt_limit_i (cnt_lim),
        .ms_limit_i  (ms_lim),
        .irq_o       (irq)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [7:0] cl, input logic [31:0] ml);
        rst_n   = 1'b0;
        acq_en  = 1'b1;
        ts_wr   = '0;
        cnt_lim = cl;
        ms_lim  = ml;
        cyc();
        cyc();
        rst_n = 1'b1;
    endtask

    // run n edges with strobes off, return how many had irq high
    task automatic quiet(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            cyc();
            if (irq) highs++;
        end
    endtask

    task automatic t_reset();
        int h;
        rst_n = 1'b0;
        acq_en = 1'b1;
        ts_wr = '1;
        cnt_lim = 8'd0;
        ms_lim = 32'd1;
        cyc();
        check("R1 irq during reset", irq, 0);
        ts_wr = '0;
        rst_n = 1'b1;
        quiet(40, h);
        check("R1 no irq after reset without strobes", h, 0);
    endtask

    task automatic t_count();
        int early;
        do_reset(8'd3, 32'd0);
        early = 0;
        ts_wr = 5'b00100;
        for (int i = 0; i < 4; i++) begin
            cyc();
            if (irq) early++;
        end
        ts_wr = '0;
        check("R2 no irq before limit exceeded", early, 0);
        cyc();
        check("R2 irq one edge after count exceeds limit", irq, 1);
        cyc();
        check("R2 irq lasts one cycle", irq, 0);
    endtask

    task automatic t_per_fifo();
        int h;
        do_reset(8'd2, 32'd0);
        ts_wr = '1;
        cyc();
        cyc();
        ts_wr = '0;
        quiet(20, h);
        check("R3 sum over limit, no single fifo over", h, 0);
        ts_wr = 5'b01000;
        cyc();
        ts_wr = '0;
        check("R3 third strobe on one fifo not yet visible", irq, 0);
        cyc();
        check("R3 irq when one fifo exceeds limit", irq, 1);
    endtask

    task automatic t_enable();
        int h;
        do_reset(8'd0, 32'd2);
        acq_en = 1'b0;
        ts_wr = '1;
        quiet(50, h);
        ts_wr = '0;
        check("R4 strobes ignored while disabled (count)", h, 0);
        quiet(100, h);
        check("R4 disabled strobes do not arm timeout", h, 0);
        acq_en = 1'b1;
        ts_wr = 5'b00001;
        cyc();
        ts_wr = '0;
        cyc();
        check("R4 enabled strobe counts", irq, 1);
    endtask

    task automatic t_timeout();
        int early;
        int h;
        do_reset(8'd200, 32'd3);
        ts_wr = 5'b10000;
        cyc();
        ts_wr = '0;
        early = 0;
        for (int e = 2; e <= 30; e++) begin
            cyc();
            if (irq) early++;
        end
        check("R5 no timeout before 3 ms", early, 0);
        cyc();
        check("R5 timeout on edge 3*MS_DIV+1", irq, 1);
        quiet(120, h);
        check("R6 no timeout without new timestamp", h, 0);
    endtask

    task automatic t_zero_limit();
        int h;
        do_reset(8'd255, 32'd0);
        ts_wr = 5'b00010;
        cyc();
        ts_wr = '0;
        quiet(300, h);
        check("R7 zero ms limit disables timeout", h, 0);
    endtask

    task automatic t_restart();
        int early;
        int h;
        // count irq at edge 3 restarts the timer; then timeout 5 ms later
        do_reset(8'd1, 32'd5);
        ts_wr = 5'b00001;
        cyc();
        cyc();
        ts_wr = '0;
        cyc();
        check("R8 count irq at edge 3", irq, 1);
        ts_wr = 5'b00010;
        cyc();
        ts_wr = '0;
        early = 0;
        for (int e = 5; e <= 53; e++) begin
            cyc();
            if (irq) early++;
        end
        check("R8 timer restarted by count irq (no early timeout)", early, 0);
        cyc();
        check("R8 timeout 5*MS_DIV+1 edges after the count irq", irq, 1);
        quiet(5, h);
        check("R8 seen flag cleared by the pulse", h, 0);
    endtask

    task automatic t_coincident();
        int h;
        do_reset(8'd0, 32'd0);
        ts_wr = 5'b00001;
        cyc();
        check("R8 first strobe not yet visible", irq, 0);
        cyc();
        ts_wr = '0;
        check("R8 irq from first strobe", irq, 1);
        cyc();
        check("R8 strobe on pulse edge counted in new interval", irq, 1);
        quiet(3, h);
        check("R8 no further irq", h, 0);
    endtask

    task automatic t_saturate();
        int h;
        do_reset(8'd255, 32'd0);
        ts_wr = 5'b10000;
        quiet(300, h);
        ts_wr = '0;
        check("R9 no irq with limit 255", h, 0);
        cnt_lim = 8'd254;
        cyc();
        check("R9 count held at 255, exceeds 254", irq, 1);
    endtask

    initial begin
        n_chk  = 0;
        n_fail = 0;
        rst_n  = 1'b0;
        acq_en = 1'b0;
        ts_wr  = '0;
        cnt_lim = '0;
        ms_lim  = '0;
        t_reset();
        t_count();
        t_per_fifo();
        t_enable();
        t_timeout();
        t_zero_limit();
        t_restart();
        t_coincident();
        t_saturate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule